// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Block

This block passes single 32-bit messages from one processor to another through a small register window. The sending processor writes a word into the data register. The receiving processor polls a status register until it sees that a word is waiting, then reads the data register. That read takes the word out and frees the single slot. The sender, in turn, polls its own view of the status register and writes a new word only after the earlier one has been taken.

Each side has its own read/write register port, with a one-cycle write strobe and a read whose result appears one cycle after the strobe. Two processors that talk in both directions use two instances of the block, one for each direction. Their register windows sit 0x8000 apart in the system map.

Top module: `mbox_regblock`

## Requirements
- R1: After a synchronous active-low reset the slot is empty, every status bit reads 0 on both ports, and both read-data outputs are 0.
- R2: Register offsets are byte offsets on the port address. The data register is at 0x0 and the status register is at 0x8. In the status word, bit 0 is the pending flag, bit 1 is the has-data flag and bit 2 is the overflow flag. Status bits 31..3 always read 0, and any other offset reads 0.
- R3: A sender write to offset 0x0 while the slot is empty stores the word. From the following cycle on, status bits 0 and 1 both read 1.
- R4: A sender write to offset 0x0 while the slot holds a word, and the receiver is not taking it in that cycle, is dropped. The stored word stays unchanged and the overflow flag (bit 2) is set. The flag stays set until it is cleared.
- R5: A receiver read of offset 0x0 while the slot is full returns the stored word. The pending flag and the has-data flag are both cleared at the same clock edge that registers the read. A receiver read of offset 0x0 while the slot is empty returns 0.
- R6: Read data appears exactly one cycle after the read strobe. In any cycle whose previous cycle had no read strobe on a port, that port's read-data output is 0.
- R7: A sender read of offset 0x0 returns the stored word (0 when empty) and does not empty the slot. Status reads on either port change nothing.
- R8: A sender write to offset 0x8 with bit 2 set clears the overflow flag. All other bits of that write are ignored.
- R9: A sender write to offset 0x0 in the same cycle as a receiver read that takes the stored word is accepted. The receiver gets the old word, and the slot stays full with the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snd_wr | input | 1 | Sender write strobe, one cycle |
| snd_rd | input | 1 | Sender read strobe, one cycle |
| snd_addr | input | ADDR_W (4) | Sender byte offset |
| snd_wdata | input | DATA_W (32) | Sender write data |
| snd_rdata | output | DATA_W (32) | Sender read data, one cycle after snd_rd |
| rcv_rd | input | 1 | Receiver read strobe, one cycle |
| rcv_addr | input | ADDR_W (4) | Receiver byte offset |
| rcv_rdata | output | DATA_W (32) | Receiver read data, one cycle after rcv_rd |

## Verification
A wrong occupancy bit shows at the very next status read on either port: the pending and has-data bits are wrong there. It also shows at the next data read, which returns 0 where a word was expected (or the reverse). A wrongly kept or replaced word shows only when the data register is next read. For that reason the bench reads the data register right after every dropped write and every same-cycle exchange. A stuck or lost overflow flag shows on the first status read after the dropped write or the clearing write. The per-cycle model compares both read-data outputs on every clock, so a wrong value appears one cycle after the read strobe that exposes it.

// File: rtl/mbox_pkg.sv
// Shared constants for the mailbox register block.
// Assumes byte offsets on the register ports, word aligned.
package mbox_pkg;
    localparam int OFS_DATA  = 0;
    localparam int OFS_STAT  = 8;
    localparam int BIT_PEND  = 0;
    localparam int BIT_AVAIL = 1;
    localparam int BIT_OVF   = 2;
    localparam int STAT_W    = 3;

    typedef struct packed {
        logic ovf;
        logic avail;
        logic pend;
    } mbox_stat_t;
endpackage

// File: rtl/mbox_slot.sv
// Single-word message slot with occupancy and sticky overflow tracking.
// Assumes pop is asserted only while full; a push that meets a pop is accepted.
module mbox_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              ovf_clr,
    output logic              full,
    output logic [DATA_W-1:0] word,
    output logic              ovf
);
    logic accept;
    logic drop;

    // Classify a push as accepted or dropped for this cycle.
    always_comb begin
        accept = push && (!full || pop);
        drop   = push && full && !pop;
    end

    // Hold the word and the occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (accept) begin
            full <= 1'b1;
            word <= push_data;
        end else if (pop) begin
            full <= 1'b0;
        end
    end

    // Sticky overflow flag; a new drop has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (drop)    ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (full && word == $past(push_data)));
    assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (full && ovf && $stable(word)));
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    assert_consume_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> !full);
    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(push && full && !pop)) |=> !ovf);
    assert_exchange_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (full && word == $past(push_data)));
endmodule

// File: rtl/mbox_rd_port.sv
// Registered read path for one side of the mailbox.
// CONSUME selects the receiver variant, whose data read takes the word out.
// Assumes one read strobe per cycle; the result shows one cycle later.
module mbox_rd_port #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter bit CONSUME = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      full,
    input  logic [DATA_W-1:0]         word,
    input  mbox_pkg::mbox_stat_t      stat,
    output logic                      pop,
    output logic [DATA_W-1:0]         rdata
);
    import mbox_pkg::*;

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic [DATA_W-1:0] next_rdata;

    // Pick the side effect that this port variant has on the slot.
    generate
        if (CONSUME) begin : g_consume
            assign pop = rd && (addr == A_DATA) && full;
        end else begin : g_peek
            assign pop = 1'b0;
        end
    endgenerate

    // Select the value that the current read returns.
    always_comb begin
        next_rdata = '0;
        if (rd) begin
            if (addr == A_DATA)      next_rdata = full ? word : '0;
            else if (addr == A_STAT) next_rdata = {{(DATA_W-STAT_W){1'b0}}, stat};
        end
    end

    // Register the read result, giving one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= next_rdata;
    end

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == '0));
    assert_stat_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_STAT) |=> (rdata[DATA_W-1:STAT_W] == '0));
endmodule

// File: rtl/mbox_regblock.sv
// One-direction mailbox: a sender port that writes messages and a
// receiver port whose data read takes them. Status is readable on both.
// Assumes DATA_W >= 3 and that both ports run on the same clock.
module mbox_regblock #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_wr,
    input  logic              snd_rd,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic [DATA_W-1:0] snd_wdata,
    output logic [DATA_W-1:0] snd_rdata,
    input  logic              rcv_rd,
    input  logic [ADDR_W-1:0] rcv_addr,
    output logic [DATA_W-1:0] rcv_rdata
);
    import mbox_pkg::*;

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic              push;
    logic              ovf_clr;
    logic              full;
    logic              ovf;
    logic              pop_rcv;
    logic              pop_snd;
    logic [DATA_W-1:0] word;
    mbox_stat_t        stat;

    // Decode sender writes into slot commands.
    always_comb begin
        push    = snd_wr && (snd_addr == A_DATA);
        ovf_clr = snd_wr && (snd_addr == A_STAT) && snd_wdata[BIT_OVF];
    end

    // Assemble the status word seen by both ports.
    always_comb begin
        stat.pend  = full;
        stat.avail = full;
        stat.ovf   = ovf;
    end

    mbox_slot #(.DATA_W(DATA_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(snd_wdata),
        .pop(pop_rcv), .ovf_clr(ovf_clr),
        .full(full), .word(word), .ovf(ovf)
    );

    mbox_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONSUME(1'b0)) u_snd_port (
        .clk(clk), .rst_n(rst_n),
        .rd(snd_rd), .addr(snd_addr),
        .full(full), .word(word), .stat(stat),
        .pop(pop_snd), .rdata(snd_rdata)
    );

    mbox_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONSUME(1'b1)) u_rcv_port (
        .clk(clk), .rst_n(rst_n),
        .rd(rcv_rd), .addr(rcv_addr),
        .full(full), .word(word), .stat(stat),
        .pop(pop_rcv), .rdata(rcv_rdata)
    );

    assert_peek_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_rcv) |=> full);
    assert_no_peek_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_snd);
    assert_flags_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_rd && rcv_addr == A_DATA && full && !push) |=> (stat.pend == 1'b0 && stat.avail == 1'b0));
endmodule

// File: tb/sim_mbox_regblock.sv
`timescale 1ns/1ps
module sim_mbox_regblock;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snd_wr = 1'b0, snd_rd = 1'b0, rcv_rd = 1'b0;
    logic [AW-1:0] snd_addr = '0, rcv_addr = '0;
    logic [DW-1:0] snd_wdata = '0;
    logic [DW-1:0] snd_rdata, rcv_rdata;

    integer checks = 0;
    integer errors = 0;
    bit     done = 1'b0;
    string  cur_tag = "R1";

    // Behavioural reference state.
    bit          m_full = 1'b0, m_ovf = 1'b0;
    logic [31:0] m_word = '0;
    logic [31:0] e_snd = '0, e_rcv = '0;

    always #2.5 clk = ~clk;

    mbox_regblock #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .snd_wr(snd_wr), .snd_rd(snd_rd), .snd_addr(snd_addr),
        .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
        .rcv_rd(rcv_rd), .rcv_addr(rcv_addr), .rcv_rdata(rcv_rdata)
    );

    function automatic logic [31:0] view(input logic [3:0] a, input bit f,
                                         input logic [31:0] w, input bit o);
        if (a == 4'h0) return f ? w : 32'h0;
        if (a == 4'h8) return {29'h0, o, f, f};
        return 32'h0;
    endfunction

    // Reference model: update expected outputs and state on each edge.
    always @(posedge clk) begin
        bit take;
        if (!rst_n) begin
            m_full = 0; m_ovf = 0; m_word = '0; e_snd = '0; e_rcv = '0;
        end else begin
            e_snd = snd_rd ? view(snd_addr, m_full, m_word, m_ovf) : 32'h0;
            e_rcv = rcv_rd ? view(rcv_addr, m_full, m_word, m_ovf) : 32'h0;
            take = rcv_rd && rcv_addr == 4'h0 && m_full;
            if (snd_wr && snd_addr == 4'h0) begin
                if (!m_full || take) begin m_word = snd_wdata; m_full = 1; end
                else m_ovf = 1;
            end else if (take) m_full = 0;
            if (snd_wr && snd_addr == 4'h8 && snd_wdata[2]) m_ovf = 0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare both ports against the model on every clock.
    always @(negedge clk) begin
        if (!done) begin
            check({cur_tag, " snd"}, snd_rdata, e_snd);
            check({cur_tag, " rcv"}, rcv_rdata, e_rcv);
        end
    end

    task automatic cyc(input bit sw, input bit sr, input logic [3:0] sa,
                       input logic [31:0] sd, input bit rr, input logic [3:0] ra);
        snd_wr = sw; snd_rd = sr; snd_addr = sa; snd_wdata = sd;
        rcv_rd = rr; rcv_addr = ra;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 4'h0, 32'h0, 0, 4'h0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset snd", snd_rdata, 32'h0);
        rst_n = 1'b1;
        cyc(0, 1, 4'h8, 0, 1, 4'h8);
        check("R1 status snd", snd_rdata, 32'h0);
        check("R1 status rcv", rcv_rdata, 32'h0);

        cur_tag = "R2";
        cyc(0, 1, 4'h4, 0, 1, 4'hC);
        check("R2 unmapped snd", snd_rdata, 32'h0);
        check("R2 unmapped rcv", rcv_rdata, 32'h0);

        cur_tag = "R3";
        cyc(1, 0, 4'h0, 32'h0030_3041, 0, 4'h0);
        cyc(0, 1, 4'h8, 0, 1, 4'h8);
        check("R3 status snd", snd_rdata, 32'h3);
        check("R3 status rcv", rcv_rdata, 32'h3);

        cur_tag = "R7";
        cyc(0, 1, 4'h0, 0, 0, 4'h0);
        check("R7 peek word", snd_rdata, 32'h0030_3041);
        cyc(0, 1, 4'h8, 0, 0, 4'h0);
        check("R7 still full", snd_rdata, 32'h3);

        cur_tag = "R4";
        cyc(1, 0, 4'h0, 32'hDEAD_BEEF, 0, 4'h0);
        cyc(0, 1, 4'h8, 0, 0, 4'h0);
        check("R4 overflow set", snd_rdata, 32'h7);

        cur_tag = "R5";
        cyc(0, 0, 4'h0, 0, 1, 4'h0);
        check("R5 word kept after drop", rcv_rdata, 32'h0030_3041);
        cyc(0, 1, 4'h8, 0, 1, 4'h8);
        check("R5 flags cleared snd", snd_rdata, 32'h4);
        check("R5 flags cleared rcv", rcv_rdata, 32'h4);
        cyc(0, 0, 4'h0, 0, 1, 4'h0);
        check("R5 empty read", rcv_rdata, 32'h0);

        cur_tag = "R6";
        idle();
        check("R6 idle zero", rcv_rdata, 32'h0);

        cur_tag = "R8";
        cyc(1, 0, 4'h8, 32'hFFFF_FFFB, 0, 4'h0);
        cyc(0, 1, 4'h8, 0, 0, 4'h0);
        check("R8 other bits ignored", snd_rdata, 32'h4);
        cyc(1, 0, 4'h8, 32'h0000_0004, 0, 4'h0);
        cyc(0, 1, 4'h8, 0, 0, 4'h0);
        check("R8 cleared", snd_rdata, 32'h0);

        cur_tag = "R9";
        cyc(1, 0, 4'h0, 32'h0041_0041, 0, 4'h0);
        cyc(1, 0, 4'h0, 32'h004C_3142, 1, 4'h0);
        check("R9 old word out", rcv_rdata, 32'h0041_0041);
        cyc(0, 1, 4'h8, 0, 0, 4'h0);
        check("R9 still full no ovf", snd_rdata, 32'h3);
        cyc(0, 0, 4'h0, 0, 1, 4'h0);
        check("R9 new word", rcv_rdata, 32'h004C_3142);

        cur_tag = "R4 R5 mixed";
        for (int i = 0; i < 400; i++) begin
            logic [3:0] sa, ra;
            int pick = $urandom_range(0, 2);
            sa = (pick == 0) ? 4'h0 : (pick == 1) ? 4'h8 : 4'h4;
            ra = ($urandom_range(0, 1) == 0) ? 4'h0 : 4'h8;
            cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, sa,
                $urandom, $urandom_range(0, 1) == 1, ra);
        end
        idle();
        idle();
        done = 1'b1;
        summary();
    end
endmodule